// File: doc/BRIEF.md
# Ethernet Speed and Duplex Resolution Controller

This block settles the operating mode of a 10/100 Ethernet port. It compares the locally advertised abilities with the base page received from the far end and selects the best mode that both ends share. When the far end sends no page but one of the two line receivers reports a good link, the block falls back to parallel detection. A small management register file lets software force a mode, advertise abilities, restart negotiation and read back the result. Each restart first holds the line quiet for a break-link interval.

The partner's base page arrives as a 16-bit word with a one-cycle valid strobe. The management bus uses an address, write data, a write strobe and combinational read data. Register addresses are 0 control, 1 basic status, 2 advertisement, 3 partner ability, 4 expansion and 5 PHY status. Ability bits in the advertisement word and the partner page are: bit 8 100 full, bit 7 100 half, bit 6 10 full, bit 5 10 half, with bits 4:0 holding the selector 00001.

Top module: `an_resolver`

## Requirements
- R1: When a partner page is received, the mode is the highest ability set in both the advertisement bits 8:5 and the page bits 8:5, ranked 100 full, 100 half, 10 full, 10 half. Completion, speed100 and full_duplex update on the clock edge that takes the strobe.
- R2: While control bit 12 is 0, speed100 follows control bit 13 and full_duplex follows control bit 8. While bit 12 is 1, those two bits have no effect on the outputs.
- R3: A control write with bits 12 and 9 set starts a restart (link_hold rises after that edge). Bit 9 always reads back as 0.
- R4: Once complete, loss of the receiver link for the resolved speed starts a restart.
- R5: On each restart, link_hold stays high for exactly BREAK_CYCLES cycles. an_complete stays low during that time, and negotiation then resumes.
- R6: Parallel detection completes when exactly one receiver reports good link and no page is present. The partner register then reads 0081h for 100 Mb/s or 0021h for 10 Mb/s, and expansion bit 0 (partner negotiation-able) reads 0.
- R7: A parallel-detect result is always half duplex.
- R8: Expansion bit 4 is set when both receivers report good link while negotiation waits. A restart clears it.
- R9: When the port comes out of reset in forced mode (strap_an_en 0), negotiation starts only when control bit 12 is written 1 after reading 0. Writing 1 to bit 12 while it is already 1, with bit 9 clear, starts nothing.
- R10: A page with no common ability leaves an_complete at 0 and the outputs at 10 Mb/s half duplex. The page is still stored, and expansion bit 0 reads 1.
- R11: Status bit 5 and PHY status bit 4 report completion. PHY status bit 2 reports duplex and bit 1 reports speed (1 = 100). Bits 2 and 1 read 0 unless negotiation is complete or disabled.
- R12: The advertisement register resets to 01E1h. Only bits 8:5 are writable, and bits 4:0 always read 00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_an_en | input | 1 | Reset value of the negotiation enable bit |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_addr | input | ADDR_W | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data (combinational) |
| lp_page | input | 16 | Received partner base page |
| lp_page_valid | input | 1 | One-cycle strobe for lp_page |
| link10_good | input | 1 | 10 Mb/s receiver link good |
| link100_good | input | 1 | 100 Mb/s receiver link good |
| speed100 | output | 1 | Resolved or forced speed, 1 = 100 Mb/s |
| full_duplex | output | 1 | Resolved or forced duplex |
| an_complete | output | 1 | Negotiation complete |
| link_hold | output | 1 | Break-link hold-off active; transmit and link pulses suppressed |

## Verification
The bench builds the block with BREAK_CYCLES set to 8 instead of the default count of roughly 1.5 s. This makes every hold-off short enough to count edge by edge, and several restarts fit into one run. The bench counts the exact hold length and checks that completion stays low through it. Link loss, register restarts and the forced-to-enabled transition each run through the full hold-off and back into parallel detection.

// File: rtl/an_resolver.sv
module an_resolver #(
  parameter int ADDR_W       = 3,
  parameter int BREAK_CYCLES = 37500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_an_en,
  input  logic              mgmt_we,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [15:0]       mgmt_wdata,
  output logic [15:0]       mgmt_rdata,
  input  logic [15:0]       lp_page,
  input  logic              lp_page_valid,
  input  logic              link10_good,
  input  logic              link100_good,
  output logic              speed100,
  output logic              full_duplex,
  output logic              an_complete,
  output logic              link_hold
);
  localparam int CNT_W = $clog2(BREAK_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ADV = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LP  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_EXP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_PHY = ADDR_W'(5);

  typedef enum logic [1:0] {S_FORCED, S_BREAK, S_NEG, S_DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             ctl_speed, ctl_an, ctl_dup;
  logic [3:0]       adv;
  logic [15:0]      lp_reg;
  logic             lp_able, pd_fault;
  logic             res_spd, res_dup;
  logic [3:0]       common;
  logic             ctl_wr, lost;

  wire unused_wd = ^{mgmt_wdata[15:14], mgmt_wdata[11:10], mgmt_wdata[4:0]};

  assign ctl_wr = mgmt_we && mgmt_addr == A_CTL;
  assign common = adv & lp_page[8:5];
  assign lost   = res_spd ? !link100_good : !link10_good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= strap_an_en ? S_NEG : S_FORCED;
      cnt       <= '0;
      ctl_speed <= 1'b0;
      ctl_an    <= strap_an_en;
      ctl_dup   <= 1'b0;
      adv       <= 4'hF;
      lp_reg    <= '0;
      lp_able   <= 1'b0;
      pd_fault  <= 1'b0;
      res_spd   <= 1'b0;
      res_dup   <= 1'b0;
    end else begin
      if (mgmt_we && mgmt_addr == A_ADV) adv <= mgmt_wdata[8:5];
      if (ctl_wr) begin
        ctl_speed <= mgmt_wdata[13];
        ctl_an    <= mgmt_wdata[12];
        ctl_dup   <= mgmt_wdata[8];
      end
      if (ctl_wr && !mgmt_wdata[12]) begin
        st      <= S_FORCED;
        res_spd <= 1'b0;
        res_dup <= 1'b0;
      end else if ((ctl_wr && (!ctl_an || mgmt_wdata[9])) || (st == S_DONE && lost)) begin
        st       <= S_BREAK;
        cnt      <= '0;
        lp_reg   <= '0;
        lp_able  <= 1'b0;
        pd_fault <= 1'b0;
        res_spd  <= 1'b0;
        res_dup  <= 1'b0;
      end else begin
        case (st)
          S_BREAK: begin
            if (cnt == CNT_W'(BREAK_CYCLES - 1)) st <= S_NEG;
            else cnt <= cnt + 1'b1;
          end
          S_NEG: begin
            if (lp_page_valid) begin
              lp_reg  <= lp_page;
              lp_able <= 1'b1;
              if (common != 4'd0) begin
                st      <= S_DONE;
                res_spd <= common[3] | common[2];
                res_dup <= common[3] | (!common[2] & common[1]);
              end
            end else if (link10_good ^ link100_good) begin
              st      <= S_DONE;
              lp_reg  <= link100_good ? 16'h0081 : 16'h0021;
              lp_able <= 1'b0;
              res_spd <= link100_good;
              res_dup <= 1'b0;
            end else if (link10_good && link100_good) begin
              pd_fault <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic valid_md;
  assign an_complete = st == S_DONE;
  assign link_hold   = st == S_BREAK;
  assign speed100    = ctl_an ? res_spd : ctl_speed;
  assign full_duplex = ctl_an ? res_dup : ctl_dup;
  assign valid_md    = an_complete || !ctl_an;

  always_comb begin
    case (mgmt_addr)
      A_CTL:   mgmt_rdata = {2'b00, ctl_speed, ctl_an, 3'b000, ctl_dup, 8'h00};
      A_STS:   mgmt_rdata = {1'b0, 4'hF, 5'b00000, an_complete, 1'b0, 1'b1,
                             link10_good | link100_good, 2'b00};
      A_ADV:   mgmt_rdata = {7'b0000000, adv, 5'b00001};
      A_LP:    mgmt_rdata = lp_reg;
      A_EXP:   mgmt_rdata = {11'h000, pd_fault, 3'b000, lp_able};
      A_PHY:   mgmt_rdata = {11'h000, an_complete, 1'b0, valid_md & full_duplex,
                             valid_md & speed100, 1'b0};
      default: mgmt_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/an_resolver_chk.sv
module an_resolver_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mgmt_we,
  input logic [ADDR_W-1:0] mgmt_addr,
  input logic [15:0]       mgmt_wdata,
  input logic              speed100,
  input logic              full_duplex,
  input logic              an_complete,
  input logic              link_hold,
  input logic              ctl_an,
  input logic              lp_able
);
  AST_NO_DONE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    link_hold |-> !an_complete); // R5
  AST_SAFE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_an && !an_complete) |-> (!speed100 && !full_duplex)); // R10
  AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    an_complete |-> ctl_an); // R2
  AST_PD_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (an_complete && !lp_able) |-> !full_duplex); // R7
  AST_FORCE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_we && mgmt_addr == '0 && !mgmt_wdata[12]) |=> (!an_complete && !link_hold)); // R9
endmodule

bind an_resolver an_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/an_resolver_tb.sv
module an_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_an_en = 1'b1;
  logic        mgmt_we = 1'b0;
  logic [2:0]  mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic [15:0] lp_page = '0;
  logic        lp_page_valid = 1'b0;
  logic        link10_good = 1'b0, link100_good = 1'b0;
  logic        speed100, full_duplex, an_complete, link_hold;
  int          errors = 0, checks = 0, cyc = 0;

  always #2.5 clk = ~clk;

  an_resolver #(.ADDR_W(3), .BREAK_CYCLES(8)) u_dut (.*);

  // fields: [10:7] adv, [6:3] page, [2] complete, [1] speed100, [0] full
  localparam logic [10:0] VEC [0:7] = '{
    {4'hF, 4'hF, 3'b111}, {4'hF, 4'h7, 3'b110}, {4'h3, 4'hF, 3'b101},
    {4'h1, 4'hF, 3'b100}, {4'hA, 4'h5, 3'b000}, {4'hC, 4'h6, 3'b110},
    {4'h2, 4'h3, 3'b101}, {4'h8, 4'h8, 3'b111}};

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); mgmt_we = 1'b1; mgmt_addr = a; mgmt_wdata = d;
    @(negedge clk); mgmt_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    mgmt_addr = a; #0.5; d = mgmt_rdata;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; strap_an_en = strap; link10_good = 0; link100_good = 0; lp_page_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic hold_len(output int n);
    n = 0;
    while (link_hold && n < 100) begin n++; @(negedge clk); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int n;
    do_reset(1'b1);
    rd(3'd0, r); check("R9 reset ctl", r, 16'h1000);
    rd(3'd2, r); check("R12 reset adv", r, 16'h01E1);
    check("R5 reset flags", {14'd0, an_complete, link_hold}, 16'h0);
    wr(3'd2, 16'hFFFF); rd(3'd2, r); check("R12 adv ones", r, 16'h01E1);
    wr(3'd2, 16'h0000); rd(3'd2, r); check("R12 adv zeros", r, 16'h0001);

    for (int i = 0; i < 8; i++) begin
      do_reset(1'b1);
      wr(3'd2, {7'd0, VEC[i][10:7], 5'b00001});
      @(negedge clk);
      lp_page = {7'd0, VEC[i][6:3], 5'b00001}; lp_page_valid = 1'b1;
      link100_good = VEC[i][2] & VEC[i][1];
      link10_good  = VEC[i][2] & !VEC[i][1];
      @(negedge clk); lp_page_valid = 1'b0;
      check($sformatf("R1 R10 vec%0d outputs", i), {13'd0, an_complete, speed100, full_duplex},
            {13'd0, VEC[i][2:0]});
      rd(3'd5, r);
      check($sformatf("R11 vec%0d phy", i), r, {11'd0, VEC[i][2], 1'b0, VEC[i][0], VEC[i][1], 1'b0});
      rd(3'd1, r); check($sformatf("R11 vec%0d sts5", i), {15'd0, r[5]}, {15'd0, VEC[i][2]});
      rd(3'd4, r); check($sformatf("R10 vec%0d lp_able", i), r, 16'h0001);
    end

    wr(3'd0, 16'h1200);
    check("R3 restart hold", {15'd0, link_hold}, 16'h1);
    rd(3'd0, r); check("R3 bit9 reads 0", r, 16'h1000);

    do_reset(1'b1);
    @(negedge clk); link100_good = 1'b1;
    @(negedge clk);
    check("R6 R7 pd100 outputs", {13'd0, an_complete, speed100, full_duplex}, 16'h0006);
    rd(3'd3, r); check("R6 pd100 lp", r, 16'h0081);
    rd(3'd4, r); check("R6 pd100 exp", r, 16'h0000);
    link100_good = 1'b0;
    @(negedge clk);
    check("R4 link loss restart", {15'd0, link_hold}, 16'h1);
    link10_good = 1'b1;
    hold_len(n); check("R5 hold length", 16'(n), 16'd8);
    @(negedge clk);
    check("R7 pd10 outputs", {13'd0, an_complete, speed100, full_duplex}, 16'h0004);
    rd(3'd3, r); check("R6 pd10 lp", r, 16'h0021);

    do_reset(1'b1);
    link10_good = 1'b1; link100_good = 1'b1;
    @(negedge clk);
    rd(3'd4, r); check("R8 fault set", r, 16'h0010);
    check("R8 not complete", {15'd0, an_complete}, 16'h0);
    wr(3'd0, 16'h1200);
    rd(3'd4, r); check("R8 fault cleared", r, 16'h0000);

    do_reset(1'b0);
    rd(3'd0, r); check("R9 forced reset ctl", r, 16'h0000);
    wr(3'd0, 16'h2100);
    check("R2 forced outputs", {13'd0, an_complete, speed100, full_duplex}, 16'h0003);
    rd(3'd5, r); check("R11 forced phy", r, 16'h0006);
    wr(3'd0, 16'h3100);
    check("R9 enable starts hold", {15'd0, link_hold}, 16'h1);
    check("R2 bits ignored", {14'd0, speed100, full_duplex}, 16'h0);
    hold_len(n); check("R5 hold after enable", 16'(n), 16'd8);
    wr(3'd0, 16'h1000);
    check("R9 rewrite no restart", {15'd0, link_hold}, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule